// File: doc/BRIEF.md
# Tile Resize Coefficient and Extent Calculator

This block works out the scaling figures for one dimension of one tile in a tiled image scaler. A request supplies the tile's input size, a power-of-two pre-decimation shift, the wanted output size, whether the dimension is horizontal or vertical, and a rounding flag. The block returns three results. The first is a step coefficient in units of 1/8192 of a decimated input pixel per output pixel. The second is the output size padded to the write-burst granule of the dimension. The third is the number of input pixels the tile must fetch so that every output pixel has the samples it needs.

The computation runs under a start/done handshake. Control is a five-state machine. ST_IDLE waits for a start request and captures the operands. ST_SETUP checks the output size and loads a restoring divider; a zero output size jumps straight to ST_FINISH with an error. ST_DIVIDE produces one quotient bit per cycle. ST_SCALE turns the coefficient into the padded size and the input extent, then registers all results. ST_FINISH raises done for one cycle and returns to ST_IDLE. Results stay on the outputs until the next accepted request completes.

In closest mode the coefficient division rounds to nearest. Each tile's last sample then lands close to where the next tile starts. In round-down mode the division truncates, so sampling never runs past the input edge.

Top module: `resz_coeff_calc`

## Requirements
- R1: With the rounding flag low, coeff_o = floor(8192*(D-1)/(O-1)), where D = in_size_i >> dshift_i and O = out_size_i.
- R2: With the rounding flag high, coeff_o = floor((8192*(D-1) + floor((O-1)/2)) / (O-1)), which rounds the ratio to nearest.
- R3: If O = 1, or D is 0 or 1, coeff_o is 0 and err_o stays low.
- R4: If O = 0, err_o is high in the done cycle, done_o comes 2 cycles after the start edge, and coeff_o, resized_o and in_ext_o are all 0.
- R5: resized_o is O rounded up to a multiple of 8 when vert_i is 0 (horizontal), and to a multiple of 2 when vert_i is 1 (vertical).
- R6: The last output pixel L is resized_o-1. In closest mode L becomes resized_o when L*coeff is not a multiple of 8192. In round-down mode L is never changed.
- R7: in_ext_o = (ceil(L*coeff/8192)+1) << dshift_i, rounded up to a multiple of 8 horizontally and of 2 vertically.
- R8: A start request accepted at a clock edge produces done_o high in the cycle after the 29th edge from that edge (latency Q_W+3 cycles with Q_W = SIZE_W+13). done_o is high for exactly one cycle.
- R9: start_i is ignored while a request is in progress, including the done cycle. It changes neither the results nor the timing, and it raises no extra done_o.
- R10: While reset is held and after it is released, done_o, err_o, coeff_o, resized_o and in_ext_o are 0.
- R11: Outside the done cycle the result outputs do not change, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse, sampled only in ST_IDLE |
| in_size_i | input | SIZE_W | Tile input size in pixels |
| dshift_i | input | DSH_W | Pre-decimation shift (divide by 2^dshift) |
| out_size_i | input | SIZE_W | Wanted tile output size |
| vert_i | input | 1 | 0 = horizontal (granule 8), 1 = vertical (granule 2) |
| closest_i | input | 1 | 1 = round to nearest and nudge last pixel, 0 = truncate |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Zero output size rejected, valid with done_o |
| coeff_o | output | SIZE_W+13 | Step coefficient, 1/8192 units |
| resized_o | output | SIZE_W+1 | Output size padded to the granule |
| in_ext_o | output | 2*SIZE_W+2^DSH_W+2 | Required input extent |

## Verification
Two functions can fall in the same cycle: acceptance of a new request, and the completion of the one in progress. The bench provokes the overlap by pulsing start_i midway through the divide, and again exactly in the done cycle, with different operands each time. Each overlap is judged correct only if the first job's results and latency are unchanged and no further done_o appears afterwards. A second overlap lies inside ST_SCALE, where the closest-mode nudge of the last pixel and the burst rounding of the extent both act on the same product. Vector pairs that differ only in the rounding flag show both effects at once.

// File: rtl/resz_pkg.sv
package resz_pkg;

    // Fractional bits of the coefficient (1/8192 units).
    localparam int RESZ_FRAC_W = 13;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_DIVIDE,
        ST_SCALE,
        ST_FINISH
    } calc_state_e;

endpackage

// File: rtl/resz_restoring_div.sv
// Restoring divider, one quotient bit per step.
module resz_restoring_div #(
    parameter int N_W = 26,
    parameter int D_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [N_W-1:0] num_i,
    input  logic [D_W-1:0] den_i,
    output logic [N_W-1:0] quo_o
);

    logic [D_W-1:0] rem_q;
    logic [N_W-1:0] quo_q;
    logic [D_W:0]   trial;
    logic [D_W:0]   trial_sub;
    logic           fits;

    always_comb begin
        trial     = {rem_q, quo_q[N_W-1]};
        trial_sub = trial - {1'b0, den_i};
        fits      = (trial >= {1'b0, den_i});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
        end else if (load_i) begin
            rem_q <= '0;
            quo_q <= num_i;
        end else if (step_i) begin
            rem_q <= fits ? trial_sub[D_W-1:0] : trial[D_W-1:0];
            quo_q <= {quo_q[N_W-2:0], fits};
        end
    end

    assign quo_o = quo_q;

endmodule

// File: rtl/resz_extent.sv
// Pads the output size and back-computes the input extent from the coefficient.
module resz_extent #(
    parameter int SIZE_W = 13,
    parameter int DSH_W  = 2,
    parameter int FRAC_W = 13,
    parameter int Q_W    = SIZE_W + FRAC_W,
    parameter int RES_W  = SIZE_W + 1,
    parameter int PROD_W = RES_W + Q_W,
    parameter int CEIL_W = PROD_W - FRAC_W + 1,
    parameter int EXT_W  = CEIL_W + (1 << DSH_W)
) (
    input  logic [Q_W-1:0]    coeff_i,
    input  logic [SIZE_W-1:0] out_size_i,
    input  logic [DSH_W-1:0]  dshift_i,
    input  logic              vert_i,
    input  logic              closest_i,
    output logic [RES_W-1:0]  resized_o,
    output logic [EXT_W-1:0]  in_ext_o
);

    localparam logic [PROD_W-1:0] FRAC_ONES = PROD_W'((1 << FRAC_W) - 1);

    logic [RES_W-1:0]  pad_sum;
    logic [RES_W-1:0]  padded;
    logic [RES_W-1:0]  last_px;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] prod_adj;
    logic [PROD_W-1:0] prod_up;
    logic              nudge;
    logic [CEIL_W-1:0] ceil_v;
    logic [CEIL_W-1:0] span;
    logic [EXT_W-1:0]  shifted;
    logic [EXT_W-1:0]  ext_sum;

    always_comb begin
        pad_sum  = RES_W'(out_size_i) + (vert_i ? RES_W'(1) : RES_W'(7));
        padded   = vert_i ? {pad_sum[RES_W-1:1], 1'b0} : {pad_sum[RES_W-1:3], 3'b000};
        last_px  = padded - RES_W'(1);
        prod     = PROD_W'(last_px) * PROD_W'(coeff_i);
        nudge    = closest_i && (prod[FRAC_W-1:0] != '0);
        prod_adj = nudge ? prod + PROD_W'(coeff_i) : prod;
        prod_up  = prod_adj + FRAC_ONES;
        ceil_v   = CEIL_W'(prod_up >> FRAC_W);
        span     = ceil_v + CEIL_W'(1);
        shifted  = EXT_W'(span) << dshift_i;
        ext_sum  = shifted + (vert_i ? EXT_W'(1) : EXT_W'(7));
        in_ext_o = vert_i ? {ext_sum[EXT_W-1:1], 1'b0} : {ext_sum[EXT_W-1:3], 3'b000};
        resized_o = padded;
    end

endmodule

// File: rtl/resz_coeff_calc.sv
module resz_coeff_calc
    import resz_pkg::*;
#(
    parameter int SIZE_W = 13,
    parameter int DSH_W  = 2,
    localparam int FRAC_W = RESZ_FRAC_W,
    localparam int Q_W    = SIZE_W + FRAC_W,
    localparam int RES_W  = SIZE_W + 1,
    localparam int PROD_W = RES_W + Q_W,
    localparam int CEIL_W = PROD_W - FRAC_W + 1,
    localparam int EXT_W  = CEIL_W + (1 << DSH_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [SIZE_W-1:0] in_size_i,
    input  logic [DSH_W-1:0]  dshift_i,
    input  logic [SIZE_W-1:0] out_size_i,
    input  logic              vert_i,
    input  logic              closest_i,
    output logic              done_o,
    output logic              err_o,
    output logic [Q_W-1:0]    coeff_o,
    output logic [RES_W-1:0]  resized_o,
    output logic [EXT_W-1:0]  in_ext_o
);

    localparam int CNT_W = $clog2(Q_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(Q_W - 1);

    calc_state_e state_q, state_d;

    logic [SIZE_W-1:0] in_q;
    logic [SIZE_W-1:0] out_q;
    logic [DSH_W-1:0]  dsh_q;
    logic              vert_q;
    logic              close_q;
    logic              err_q;
    logic [CNT_W-1:0]  bit_q;

    logic [SIZE_W-1:0] decimated;
    logic [SIZE_W-1:0] den;
    logic [Q_W-1:0]    num_base;
    logic [Q_W-1:0]    dividend;
    logic              den_zero;
    logic [Q_W-1:0]    quotient;
    logic [Q_W-1:0]    coeff_eff;
    logic [RES_W-1:0]  resized_c;
    logic [EXT_W-1:0]  ext_c;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_SETUP;
            ST_SETUP:  state_d = err_q ? ST_FINISH : ST_DIVIDE;
            ST_DIVIDE: if (bit_q == LAST_BIT) state_d = ST_SCALE;
            ST_SCALE:  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Division operands
    always_comb begin
        decimated = in_q >> dsh_q;
        den       = out_q - SIZE_W'(1);
        den_zero  = (den == '0);
        num_base  = (decimated == '0) ? '0 : {decimated - SIZE_W'(1), {FRAC_W{1'b0}}};
        dividend  = num_base + (close_q ? Q_W'(den >> 1) : '0);
        coeff_eff = den_zero ? '0 : quotient;
    end

    resz_restoring_div #(
        .N_W (Q_W),
        .D_W (SIZE_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (state_q == ST_SETUP),
        .step_i (state_q == ST_DIVIDE),
        .num_i  (dividend),
        .den_i  (den),
        .quo_o  (quotient)
    );

    resz_extent #(
        .SIZE_W (SIZE_W),
        .DSH_W  (DSH_W),
        .FRAC_W (FRAC_W)
    ) u_ext (
        .coeff_i    (coeff_eff),
        .out_size_i (out_q),
        .dshift_i   (dsh_q),
        .vert_i     (vert_q),
        .closest_i  (close_q),
        .resized_o  (resized_c),
        .in_ext_o   (ext_c)
    );

    // Operand capture, bit counter and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q      <= '0;
            out_q     <= '0;
            dsh_q     <= '0;
            vert_q    <= 1'b0;
            close_q   <= 1'b0;
            err_q     <= 1'b0;
            bit_q     <= '0;
            coeff_o   <= '0;
            resized_o <= '0;
            in_ext_o  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        in_q    <= in_size_i;
                        out_q   <= out_size_i;
                        dsh_q   <= dshift_i;
                        vert_q  <= vert_i;
                        close_q <= closest_i;
                        err_q   <= (out_size_i == '0);
                    end
                end
                ST_SETUP: begin
                    bit_q <= '0;
                    if (err_q) begin
                        coeff_o   <= '0;
                        resized_o <= '0;
                        in_ext_o  <= '0;
                    end
                end
                ST_DIVIDE: bit_q <= bit_q + CNT_W'(1);
                ST_SCALE: begin
                    coeff_o   <= coeff_eff;
                    resized_o <= resized_c;
                    in_ext_o  <= ext_c;
                end
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        done_o = (state_q == ST_FINISH);
        err_o  = (state_q == ST_FINISH) && err_q;
    end

endmodule

// File: rtl/resz_coeff_chk.sv
module resz_coeff_chk #(
    parameter int SIZE_W = 13,
    parameter int DSH_W  = 2,
    parameter int Q_W    = SIZE_W + 13,
    parameter int RES_W  = SIZE_W + 1,
    parameter int EXT_W  = 2 * SIZE_W + (1 << DSH_W) + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             done_o,
    input logic             err_o,
    input logic [Q_W-1:0]   coeff_o,
    input logic [RES_W-1:0] resized_o,
    input logic [EXT_W-1:0] in_ext_o
);

    localparam int LAT   = Q_W + 3;
    localparam int CW    = $clog2(LAT + 2);

    logic          busy;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (start_i) begin
                busy <= 1'b1;
                cnt  <= CW'(1);
            end
        end else begin
            if (done_o) busy <= 1'b0;
            if (cnt != CW'(LAT + 1)) cnt <= cnt + CW'(1);
        end
    end

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy && ((cnt == CW'(LAT)) || (err_o && cnt == CW'(2)))));

    a_r9_done_needs_job: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt > CW'(2) && cnt < CW'(LAT)) |-> !done_o);

    a_r4_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (done_o && coeff_o == '0 && resized_o == '0 && in_ext_o == '0));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(coeff_o) && $stable(resized_o) && $stable(in_ext_o)));

    a_r5_even_sizes: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (!resized_o[0] && !in_ext_o[0]));

endmodule

bind resz_coeff_calc resz_coeff_chk #(
    .SIZE_W (SIZE_W),
    .DSH_W  (DSH_W),
    .Q_W    (Q_W),
    .RES_W  (RES_W),
    .EXT_W  (EXT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .done_o    (done_o),
    .err_o     (err_o),
    .coeff_o   (coeff_o),
    .resized_o (resized_o),
    .in_ext_o  (in_ext_o)
);

// File: tb/tb_resz_coeff_calc.sv
module tb_resz_coeff_calc;

    localparam int SIZE_W = 13;
    localparam int DSH_W  = 2;
    localparam int Q_W    = SIZE_W + 13;
    localparam int RES_W  = SIZE_W + 1;
    localparam int PROD_W = RES_W + Q_W;
    localparam int CEIL_W = PROD_W - 13 + 1;
    localparam int EXT_W  = CEIL_W + (1 << DSH_W);
    localparam int LAT    = Q_W + 3;

    typedef struct packed {
        int in_sz;
        int dsh;
        int out_sz;
        int vert;
        int close;
        int coeff;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{1024, 0, 1024, 0, 1,  8192},   // R2 exact ratio
        '{2048, 1,  512, 0, 0, 16400},   // R1 truncation
        '{1000, 0, 1500, 1, 1,  5460},   // R2 rounds up, R6 nudge
        '{1000, 0, 1500, 1, 0,  5459},   // R1 truncates
        '{ 640, 0,  480, 1, 0, 10928},
        '{ 640, 0,  480, 0, 1, 10928},
        '{3000, 1, 1499, 0, 1,  8197},
        '{4095, 2,    1, 0, 1,     0},   // R3 single output pixel
        '{   1, 0,  100, 1, 0,     0},   // R3 decimated size 1
        '{   0, 0,  100, 0, 1,     0}    // R3 decimated size 0
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [SIZE_W-1:0] in_size_i = '0;
    logic [DSH_W-1:0]  dshift_i = '0;
    logic [SIZE_W-1:0] out_size_i = '0;
    logic              vert_i = 1'b0;
    logic              closest_i = 1'b0;
    logic              done_o;
    logic              err_o;
    logic [Q_W-1:0]    coeff_o;
    logic [RES_W-1:0]  resized_o;
    logic [EXT_W-1:0]  in_ext_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    resz_coeff_calc #(.SIZE_W(SIZE_W), .DSH_W(DSH_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_size_i(in_size_i),
        .dshift_i(dshift_i), .out_size_i(out_size_i), .vert_i(vert_i),
        .closest_i(closest_i), .done_o(done_o), .err_o(err_o),
        .coeff_o(coeff_o), .resized_o(resized_o), .in_ext_o(in_ext_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint model_resized(input longint o, input int v);
        return v ? ((o + 1) / 2) * 2 : ((o + 7) / 8) * 8;
    endfunction

    function automatic longint model_ext(input longint o, input int d, input int v,
                                         input int c, input longint k);
        longint last, p, e;
        last = model_resized(o, v) - 1;
        p = last * k;
        if (c != 0 && (p % 8192) != 0) p = (last + 1) * k;
        e = ((p + 8191) / 8192 + 1) << d;
        return v ? ((e + 1) / 2) * 2 : ((e + 7) / 8) * 8;
    endfunction

    // Issues one request; optionally pokes start at cycle poke_at with other operands.
    task automatic run(input int isz, input int d, input int osz, input int v, input int c,
                       input int poke_at, output int lat);
        int n = 0;
        @(negedge clk);
        in_size_i = SIZE_W'(isz); dshift_i = DSH_W'(d); out_size_i = SIZE_W'(osz);
        vert_i = v[0]; closest_i = c[0]; start_i = 1'b1;
        lat = -1;
        while (n < 200) begin
            @(negedge clk);
            n++;
            start_i = 1'b0;
            if (n == poke_at) begin
                start_i = 1'b1; in_size_i = 13'd77; out_size_i = 13'd0;
                vert_i = ~vert_i; closest_i = ~closest_i;
            end
            if (done_o) begin lat = n; break; end
        end
        start_i = 1'b0;
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lat;
        logic [Q_W-1:0]   sv_coeff;
        logic [RES_W-1:0] sv_res;
        logic [EXT_W-1:0] sv_ext;

        // R10 reset state
        repeat (3) @(negedge clk);
        chk("R10 done in reset", done_o, 0);
        chk("R10 coeff in reset", coeff_o, 0);
        chk("R10 ext in reset", in_ext_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 done after reset", done_o, 0);
        chk("R10 err after reset", err_o, 0);
        chk("R10 resized after reset", resized_o, 0);

        // Vector table: R1 R2 R3 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            run(VEC[i].in_sz, VEC[i].dsh, VEC[i].out_sz, VEC[i].vert, VEC[i].close, -1, lat);
            chk("R8 latency", lat, LAT);
            chk("R1/R2/R3 coeff", coeff_o, VEC[i].coeff);
            chk("R3 err low", err_o, 0);
            chk("R5 resized", resized_o, model_resized(VEC[i].out_sz, VEC[i].vert));
            chk("R6/R7 in extent", in_ext_o,
                model_ext(VEC[i].out_sz, VEC[i].dsh, VEC[i].vert, VEC[i].close, VEC[i].coeff));
            @(negedge clk);
            chk("R8 done single cycle", done_o, 0);
        end

        // R4 zero output size
        run(500, 1, 0, 0, 1, -1, lat);
        chk("R4 error latency", lat, 2);
        chk("R4 err flag", err_o, 1);
        chk("R4 coeff zero", coeff_o, 0);
        chk("R4 resized zero", resized_o, 0);
        chk("R4 ext zero", in_ext_o, 0);

        // R9 start in the middle of a divide
        run(1000, 0, 1500, 1, 1, 5, lat);
        chk("R9 latency with poke", lat, LAT);
        chk("R9 coeff with poke", coeff_o, 5460);
        chk("R9 err with poke", err_o, 0);
        chk("R9 ext with poke", in_ext_o, 1002);

        // R9 start exactly in the done cycle, then no further done
        run(640, 0, 480, 1, 0, -1, lat);
        start_i = 1'b1; out_size_i = 13'd0;
        @(negedge clk);
        start_i = 1'b0;
        begin
            int extra = 0;
            for (int k = 0; k < LAT + 5; k++) begin
                @(negedge clk);
                if (done_o) extra++;
            end
            chk("R9 no done after done-cycle start", extra, 0);
        end
        chk("R9 coeff kept", coeff_o, 10928);

        // R11 hold while idle with toggling inputs
        sv_coeff = coeff_o; sv_res = resized_o; sv_ext = in_ext_o;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            in_size_i = SIZE_W'(k * 97); out_size_i = SIZE_W'(k * 31);
            vert_i = k[0]; closest_i = k[1]; dshift_i = k[1:0];
        end
        chk("R11 coeff held", coeff_o, sv_coeff);
        chk("R11 resized held", resized_o, sv_res);
        chk("R11 ext held", in_ext_o, sv_ext);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule